// File: doc/BRIEF.md
# Receiver Channel Reset Sequencer

This block brings one serial receiver channel out of reset in a safe order and holds it there again on request. After power-up it keeps the analog and the digital reset of the channel asserted until calibration reports idle. It then runs a handshake with the analog front end. The analog reset stays asserted until the front end acknowledges it. Once the analog reset is released, the block waits for that acknowledge to clear. The digital reset comes off last.

In automatic lock mode, the digital reset is released only after the recovered clock has reported lock to the incoming data and that lock has then held for a settle interval. In manual lock mode there is no lock wait and no settle interval. If signal-detect qualification is enabled in manual mode, the sequence does not leave the hold state until signal detect has been high without a break for a qualification interval. Both intervals are counted in clock cycles derived from a clock-frequency parameter.

A reset or reconfiguration request returns the channel to the hold state. In that state the reconfiguration window output is open. Each acknowledge wait has a timeout, and an expired timeout raises an error flag and restarts the sequence. All pins are plain control and status levels. The block has no data stream, so no valid/ready flow control applies.

Top module: `rx_rst_seq`

## Requirements
- R1: While rst_n is low, and afterwards until cal_busy is low, ana_rst and dig_rst are 1 and ready is 0.
- R2: Once the sequence has started, ana_rst stays 1 until ana_ack has been sampled 1, and falls on the clock edge after that sample.
- R3: After ana_rst falls, dig_rst stays 1 while ana_ack is still 1.
- R4: In automatic mode (manual_mode=0), dig_rst falls only after locked has been 1 for at least CLK_MHZ*SETTLE_US consecutive cycles (500 with the default parameters). A drop of locked during that wait restarts the count.
- R5: In manual mode (manual_mode=1), dig_rst falls on the edge after ana_ack is sampled 0 following the analog release, whatever the value of locked.
- R6: In manual mode with sigdet_en=1, ana_rst is not released until sig_det has been 1 for at least CLK_MHZ*SIGDET_US consecutive cycles (125 with the default parameters). A low cycle on sig_det restarts the count.
- R7: reconfig_ok is 1 only while both resets are asserted in the hold state. While reset_req or reconfig_req is 1, the block stays in that state.
- R8: ready is 1 exactly when dig_rst is 0 and no request is present. It falls in the same cycle that reset_req or reconfig_req rises.
- R9: In automatic mode, if locked falls while ready is 1, dig_rst is 1 and ready is 0 on the next cycle. Release then again needs the full settle interval of R4.
- R10: If an acknowledge wait lasts ACK_TMO_CYC cycles (64 by default), ack_err becomes 1 and the sequence restarts from the hold state with ana_rst asserted. ack_err returns to 0 when ready next becomes 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_busy | input | 1 | Calibration in progress |
| ana_ack | input | 1 | Acknowledge of the analog reset from the front end |
| locked | input | 1 | Clock recovery locked to data |
| sig_det | input | 1 | Signal present on the line |
| manual_mode | input | 1 | 1 = manual lock mode, 0 = automatic lock mode |
| sigdet_en | input | 1 | Use signal-detect qualification in manual mode |
| reset_req | input | 1 | Request to reset the channel |
| reconfig_req | input | 1 | Request to reconfigure the channel |
| ana_rst | output | 1 | Analog reset to the channel |
| dig_rst | output | 1 | Digital reset to the channel |
| ready | output | 1 | Channel out of reset |
| reconfig_ok | output | 1 | Reconfiguration window open |
| ack_err | output | 1 | An acknowledge wait timed out |

## Verification
The bench measures the settle interval from the rise of locked to the fall of dig_rst. It also drops locked partway through that wait. A design that counted from the handshake instead, or that did not restart the count, would release the digital reset early. The bench breaks the signal-detect qualification with a single low cycle and then measures from the final rise. A design that kept the partial count would release the analog reset roughly 60 cycles too soon. The bench raises a request mid-cycle and reads ready at once, which catches a ready flag that lags by a register. It also leaves the acknowledge low to confirm that the error flag sets, the analog reset stays asserted, and the flag clears after a clean run.

// File: rtl/rx_rst_pkg.sv
package rx_rst_pkg;
  typedef enum logic [2:0] {
    ST_HOLD,
    ST_ANA_ON,
    ST_ANA_OFF,
    ST_LOCK,
    ST_SETTLE,
    ST_RUN
  } seq_state_e;
endpackage

// File: rtl/rx_rst_timer.sv
module rx_rst_timer #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic done
);
  localparam int unsigned W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (clr)         cnt <= '0;
    else if (run && !done) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == W'(LIMIT));
endmodule

// File: rtl/rx_rst_fsm.sv
import rx_rst_pkg::*;

module rx_rst_fsm (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cal_busy,
  input  logic       ana_ack,
  input  logic       locked,
  input  logic       manual_mode,
  input  logic       sigdet_en,
  input  logic       sd_ok,
  input  logic       settle_done,
  input  logic       ack_tmo,
  input  logic       req,
  output seq_state_e state,
  output logic       ack_clr,
  output logic       ack_run,
  output logic       settle_clr,
  output logic       settle_run,
  output logic       err
);
  seq_state_e nxt;
  logic       tmo_hit;
  logic       gate_ok;

  assign gate_ok = !(manual_mode && sigdet_en) || sd_ok;

  always_comb begin
    nxt     = state;
    tmo_hit = 1'b0;
    if (req) begin
      nxt = ST_HOLD;
    end else begin
      case (state)
        ST_HOLD:    if (!cal_busy && gate_ok) nxt = ST_ANA_ON;
        ST_ANA_ON: begin
          if (ana_ack) nxt = ST_ANA_OFF;
          else if (ack_tmo) begin
            nxt     = ST_HOLD;
            tmo_hit = 1'b1;
          end
        end
        ST_ANA_OFF: begin
          if (!ana_ack) nxt = manual_mode ? ST_RUN : ST_LOCK;
          else if (ack_tmo) begin
            nxt     = ST_HOLD;
            tmo_hit = 1'b1;
          end
        end
        ST_LOCK:    if (locked) nxt = ST_SETTLE;
        ST_SETTLE: begin
          if (!locked) nxt = ST_LOCK;
          else if (settle_done) nxt = ST_RUN;
        end
        ST_RUN:     if (!manual_mode && !locked) nxt = ST_LOCK;
        default:    nxt = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_HOLD;
      err   <= 1'b0;
    end else begin
      state <= nxt;
      if (tmo_hit) err <= 1'b1;
      else if (nxt == ST_RUN && state != ST_RUN) err <= 1'b0;
    end
  end

  assign ack_clr    = (nxt != state);
  assign ack_run    = (state == ST_ANA_ON) || (state == ST_ANA_OFF);
  assign settle_clr = (state != ST_SETTLE);
  assign settle_run = (state == ST_SETTLE);
endmodule

// File: rtl/rx_rst_seq.sv
import rx_rst_pkg::*;

module rx_rst_seq #(
  parameter int unsigned CLK_MHZ     = 125,
  parameter int unsigned SETTLE_US   = 4,
  parameter int unsigned SIGDET_US   = 1,
  parameter int unsigned ACK_TMO_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cal_busy,
  input  logic ana_ack,
  input  logic locked,
  input  logic sig_det,
  input  logic manual_mode,
  input  logic sigdet_en,
  input  logic reset_req,
  input  logic reconfig_req,
  output logic ana_rst,
  output logic dig_rst,
  output logic ready,
  output logic reconfig_ok,
  output logic ack_err
);
  localparam int unsigned SETTLE_CYC = CLK_MHZ * SETTLE_US;
  localparam int unsigned SIGDET_CYC = CLK_MHZ * SIGDET_US;

  seq_state_e state;
  logic req, sd_ok, settle_done, ack_tmo;
  logic ack_clr, ack_run, settle_clr, settle_run;

  assign req = reset_req || reconfig_req;

  rx_rst_timer #(.LIMIT(SIGDET_CYC)) u_sd_tmr (
    .clk(clk), .rst_n(rst_n), .clr(!sig_det), .run(sig_det), .done(sd_ok)
  );

  rx_rst_timer #(.LIMIT(SETTLE_CYC)) u_settle_tmr (
    .clk(clk), .rst_n(rst_n), .clr(settle_clr), .run(settle_run), .done(settle_done)
  );

  rx_rst_timer #(.LIMIT(ACK_TMO_CYC)) u_ack_tmr (
    .clk(clk), .rst_n(rst_n), .clr(ack_clr), .run(ack_run), .done(ack_tmo)
  );

  rx_rst_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cal_busy(cal_busy), .ana_ack(ana_ack),
    .locked(locked), .manual_mode(manual_mode), .sigdet_en(sigdet_en),
    .sd_ok(sd_ok), .settle_done(settle_done), .ack_tmo(ack_tmo), .req(req),
    .state(state), .ack_clr(ack_clr), .ack_run(ack_run),
    .settle_clr(settle_clr), .settle_run(settle_run), .err(ack_err)
  );

  assign ana_rst     = (state == ST_HOLD) || (state == ST_ANA_ON);
  assign dig_rst     = (state != ST_RUN);
  assign ready       = (state == ST_RUN) && !req;
  assign reconfig_ok = (state == ST_HOLD);
endmodule

// File: rtl/rx_rst_seq_chk.sv
module rx_rst_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ana_ack,
  input logic locked,
  input logic manual_mode,
  input logic reset_req,
  input logic reconfig_req,
  input logic ana_rst,
  input logic dig_rst,
  input logic ready,
  input logic reconfig_ok
);
  AST_ANA_REL_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ana_rst) |-> $past(ana_ack)); // R2

  AST_DIG_HELD_WITH_ANA: assert property (@(posedge clk) disable iff (!rst_n)
    ana_rst |-> dig_rst); // R3

  AST_AUTO_REL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dig_rst) && !manual_mode) |-> $past(locked)); // R4

  AST_WINDOW_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    reconfig_ok |-> (ana_rst && dig_rst)); // R7

  AST_REQ_KILLS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_req || reconfig_req) |-> !ready); // R8

  AST_READY_NO_DIG: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !dig_rst); // R8

  AST_LOCK_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !manual_mode && !locked) |=> (dig_rst && !ready)); // R9
endmodule

bind rx_rst_seq rx_rst_seq_chk u_chk (.*);

// File: tb/rx_rst_seq_tb.sv
module rx_rst_seq_tb;
  logic clk = 1'b0;
  logic rst_n, cal_busy, ana_ack, locked, sig_det, manual_mode, sigdet_en;
  logic reset_req, reconfig_req;
  logic ana_rst, dig_rst, ready, reconfig_ok, ack_err;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rx_rst_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cal_busy(cal_busy), .ana_ack(ana_ack),
    .locked(locked), .sig_det(sig_det), .manual_mode(manual_mode),
    .sigdet_en(sigdet_en), .reset_req(reset_req), .reconfig_req(reconfig_req),
    .ana_rst(ana_rst), .dig_rst(dig_rst), .ready(ready),
    .reconfig_ok(reconfig_ok), .ack_err(ack_err)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cnt_dig_fall(output int n);
    n = 0;
    while (dig_rst && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic cnt_ana_fall(output int n);
    n = 0;
    while (ana_rst && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic pulse_req();
    reset_req = 1'b1;
    step(2);
    reset_req = 1'b0;
  endtask

  task automatic t_powerup();
    rst_n = 1'b0; cal_busy = 1'b1; ana_ack = 1'b0; locked = 1'b0; sig_det = 1'b0;
    manual_mode = 1'b0; sigdet_en = 1'b0; reset_req = 1'b0; reconfig_req = 1'b0;
    step(3);
    chk(ana_rst && dig_rst && !ready, "R1 in reset", {ana_rst, dig_rst, ready}, 6);
    rst_n = 1'b1;
    step(20);
    chk(ana_rst && dig_rst && !ready, "R1 cal busy", {ana_rst, dig_rst, ready}, 6);
    chk(reconfig_ok == 1'b1, "R7 window in hold", reconfig_ok, 1);
  endtask

  task automatic t_auto_seq();
    int n;
    cal_busy = 1'b0;
    step(10);
    chk(ana_rst == 1'b1, "R2 wait ack", ana_rst, 1);
    chk(reconfig_ok == 1'b0, "R7 window closed", reconfig_ok, 0);
    ana_ack = 1'b1;
    step(1);
    chk(ana_rst == 1'b0, "R2 release after ack", ana_rst, 0);
    step(5);
    chk(dig_rst == 1'b1, "R3 ack still high", dig_rst, 1);
    ana_ack = 1'b0;
    step(10);
    chk(dig_rst == 1'b1, "R4 no lock yet", dig_rst, 1);
    locked = 1'b1;
    cnt_dig_fall(n);
    chk(n >= 500 && n <= 506, "R4 settle length", n, 502);
    chk(ready == 1'b1, "R8 ready after release", ready, 1);
    chk(ack_err == 1'b0, "R10 no error", ack_err, 0);
  endtask

  task automatic t_lock_loss();
    int n;
    locked = 1'b0;
    step(1);
    chk(dig_rst == 1'b1 && ready == 1'b0, "R9 lock loss", {dig_rst, ready}, 2);
    locked = 1'b1;
    step(200);
    locked = 1'b0;
    step(3);
    chk(dig_rst == 1'b1, "R4 drop in settle", dig_rst, 1);
    locked = 1'b1;
    cnt_dig_fall(n);
    chk(n >= 500 && n <= 506, "R4 restarted settle", n, 502);
    chk(ready == 1'b1, "R9 recovered", ready, 1);
  endtask

  task automatic t_request();
    @(negedge clk);
    reconfig_req = 1'b1;
    #1;
    chk(ready == 1'b0, "R8 same-cycle drop", ready, 0);
    step(2);
    chk(reconfig_ok && ana_rst && dig_rst, "R7 window open", {reconfig_ok, ana_rst, dig_rst}, 7);
    ana_ack = 1'b1;
    step(20);
    chk(reconfig_ok == 1'b1 && ana_rst == 1'b1, "R7 held while request", {reconfig_ok, ana_rst}, 3);
    ana_ack = 1'b0;
    reconfig_req = 1'b0;
  endtask

  task automatic t_manual();
    manual_mode = 1'b1;
    locked = 1'b0;
    pulse_req();
    step(3);
    ana_ack = 1'b1;
    step(2);
    chk(ana_rst == 1'b0 && dig_rst == 1'b1, "R5 analog released", {ana_rst, dig_rst}, 1);
    ana_ack = 1'b0;
    step(1);
    chk(dig_rst == 1'b0, "R5 release ignoring lock", dig_rst, 0);
    step(10);
    chk(ready == 1'b1, "R5 lock ignored", ready, 1);
  endtask

  task automatic t_sigdet();
    int n;
    sigdet_en = 1'b1;
    sig_det = 1'b0;
    ana_ack = 1'b1;
    pulse_req();
    step(300);
    chk(ana_rst == 1'b1, "R6 no signal", ana_rst, 1);
    sig_det = 1'b1;
    step(60);
    sig_det = 1'b0;
    step(1);
    sig_det = 1'b1;
    step(1);
    chk(ana_rst == 1'b1, "R6 broken run", ana_rst, 1);
    cnt_ana_fall(n);
    n = n + 1;
    chk(n >= 125 && n <= 131, "R6 qualify length", n, 127);
    ana_ack = 1'b0;
    step(3);
    chk(ready == 1'b1, "R6 sequence done", ready, 1);
    sigdet_en = 1'b0;
    manual_mode = 1'b0;
    locked = 1'b1;
  endtask

  task automatic t_timeout();
    int n;
    pulse_req();
    step(100);
    chk(ack_err == 1'b1, "R10 timeout flag", ack_err, 1);
    chk(ana_rst == 1'b1 && ready == 1'b0, "R10 restart", {ana_rst, ready}, 2);
    ana_ack = 1'b1;
    step(3);
    ana_ack = 1'b0;
    cnt_dig_fall(n);
    chk(ready == 1'b1 && ack_err == 1'b0, "R10 flag cleared", {ready, ack_err}, 2);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_powerup();
    t_auto_seq();
    t_lock_loss();
    t_request();
    t_manual();
    t_sigdet();
    t_timeout();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule